// File: doc/BRIEF.md
# Byte-lane asynchronous SRAM controller

This block connects a simple clocked host request port to a 32-bit asynchronous static RAM array. The array is made of four byte-wide banks that share one 17-bit address bus, one active-low write enable and one active-low output enable. Each bank has its own active-low chip select. The host asks for an 8-, 16- or 32-bit access at a word address and picks the byte lanes with a lane offset. The controller checks that the size and offset form a legal lane group. It then runs the bus through a fixed strobe sequence, captures the read data and reports completion with a one-cycle pulse.

The controller has four states. ST_IDLE waits for a request. On a legal request it takes the IDLE->SETUP transition; on an illegal one it stays in ST_IDLE and raises an error pulse. In ST_SETUP the address is driven and all selects stay high; the controller always moves on (SETUP->STROBE). In ST_STROBE the selected chip selects are low, together with write enable (writes) or output enable (reads). This lasts a number of cycles that is derived from the clock period and the array's access, write-pulse and data-setup times. At the end it takes STROBE->RECOVER. In ST_RECOVER every strobe is high. A write keeps driving its data for this one hold cycle. The controller then returns to idle (RECOVER->IDLE).

Write data is supplied on its natural byte lanes: the byte for lane k sits in bits 8k+7:8k. No shifting is done.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Size code 2'b00 (8-bit) with lane offset k asserts only `mem_cs_n[k]` low during the strobe. `mem_cs_n[k]` gates data bits 8k+7:8k.
- R2: Size code 2'b01 (16-bit) with offset 0 asserts `mem_cs_n[1:0]` low, and with offset 2 asserts `mem_cs_n[3:2]` low.
- R3: Size code 2'b10 (32-bit) with offset 0 asserts all four selects low.
- R4: A 16-bit request with an odd offset, a 32-bit request with a nonzero offset, or size code 2'b11 is rejected. `rsp_error` is high for exactly the cycle after the request. No select goes low, `rsp_done` does not pulse, `busy` stays low and memory is left unchanged.
- R5: An accepted request spends 1 cycle in SETUP (selects high), then STROBE_CYC cycles in STROBE (2 with default parameters), then 1 cycle in RECOVER, and then returns to IDLE. `busy` is high from SETUP through RECOVER. A request presented while `busy` is high is ignored.
- R6: During a write strobe, `mem_we_n` is low and `mem_oe_n` is high. `mem_wdata_oe` is high in STROBE and in RECOVER. `mem_wdata` holds the request data and does not change while `mem_we_n` is low.
- R7: During a read strobe, `mem_oe_n` is low, `mem_we_n` is high and `mem_wdata_oe` is low. `mem_we_n` and `mem_oe_n` are never low together.
- R8: Read data is sampled in the last STROBE cycle. Lanes that were not selected return zero. `rsp_done` is high for exactly one cycle (the RECOVER cycle), and `rsp_rdata` is valid in that cycle.
- R9: `mem_addr` does not change while any select is low, and it already holds the request address in SETUP, before any select falls.
- R10: `mem_wdata_oe` is low in the cycle before `mem_oe_n` falls, and it is never high while `mem_oe_n` is low. This gives every read that follows a write at least one turnaround cycle.
- R11: In reset and in IDLE all selects, `mem_we_n` and `mem_oe_n` are high, and `mem_wdata_oe`, `busy`, `rsp_done` and `rsp_error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_size | input | 2 | 00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 = illegal |
| req_offset | input | 2 | First byte lane of the access |
| req_wdata | input | 32 | Write data on natural byte lanes |
| busy | output | 1 | Access in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | One-cycle rejection pulse |
| rsp_rdata | output | 32 | Captured read data, unselected lanes zero |
| mem_addr | output | 17 | Shared array address |
| mem_cs_n | output | 4 | Per-lane chip selects, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_wdata | output | 32 | Data toward the array |
| mem_wdata_oe | output | 1 | Data driver enable toward the array |
| mem_rdata | input | 32 | Data returned by the array |

## Verification
The bench attacks lane grouping at its edges. A misaligned 16-bit request, an offset 32-bit request and the reserved size code must all bounce without touching the bus; a decoder that shifts instead would corrupt neighbouring bytes, which later read-backs expose. Reads are served by a bank model that puts junk on unselected lanes, so a controller that forgets to zero-fill returns that junk. A write directly followed by a read tests the turnaround: a controller that drops the hold cycle, or overlaps its data driver with output enable, is flagged the cycle output enable falls. A request pushed in mid-access must leave no trace on the target address.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RECOVER
    } ctrl_state_e;

    function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_lane_decode.sv
module sram_lane_decode
    import sram_lane_pkg::*;
#(
    parameter int unsigned LANES = 4,
    localparam int unsigned OFFW = $clog2(LANES)
) (
    input  acc_size_e         size,
    input  logic [OFFW-1:0]   offset,
    output logic [LANES-1:0]  lane_mask,
    output logic              reject
);
    always_comb begin
        lane_mask = '0;
        reject    = 1'b0;
        unique case (size)
            SZ_BYTE: lane_mask = LANES'(1) << offset;
            SZ_HALF: begin
                if (offset[0]) reject = 1'b1;
                else           lane_mask = LANES'(3) << offset;
            end
            SZ_WORD: begin
                if (offset != '0) reject = 1'b1;
                else              lane_mask = '1;
            end
            SZ_BAD:  reject = 1'b1;
        endcase
    end
endmodule

// File: rtl/sram_strobe_timer.sv
module sram_strobe_timer #(
    parameter int unsigned CYCLES = 2,
    localparam int unsigned CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    logic [CW-1:0] cnt;

    assign last = run && (cnt == CW'(CYCLES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (!last)     cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned LANES = 4,
    localparam int unsigned DW = LANES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic [LANES-1:0] lane_mask,
    input  logic [DW-1:0]    bus_data,
    output logic [DW-1:0]    rdata
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                rdata[8*k +: 8] <= '0;
            else if (sample)
                rdata[8*k +: 8] <= lane_mask[k] ? bus_data[8*k +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int unsigned AW            = 17,
    parameter int unsigned LANES         = 4,
    parameter int unsigned CLK_PERIOD_NS = 5,
    parameter int unsigned T_ACC_NS      = 10,
    parameter int unsigned T_WP_NS       = 8,
    parameter int unsigned T_DS_NS       = 6,
    localparam int unsigned DW   = LANES * 8,
    localparam int unsigned OFFW = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [1:0]       req_size,
    input  logic [OFFW-1:0]  req_offset,
    input  logic [DW-1:0]    req_wdata,
    output logic             busy,
    output logic             rsp_done,
    output logic             rsp_error,
    output logic [DW-1:0]    rsp_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic [LANES-1:0] mem_cs_n,
    output logic             mem_we_n,
    output logic             mem_oe_n,
    output logic [DW-1:0]    mem_wdata,
    output logic             mem_wdata_oe,
    input  logic [DW-1:0]    mem_rdata
);
    localparam int unsigned STROBE_CYC =
        umax(umax(cdiv(T_ACC_NS, CLK_PERIOD_NS), cdiv(T_WP_NS, CLK_PERIOD_NS)),
             umax(cdiv(T_DS_NS, CLK_PERIOD_NS), 1));

    ctrl_state_e      state, state_nx;
    logic [LANES-1:0] dec_mask, mask_q;
    logic             dec_reject;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    logic             wr_q;
    logic             strobe_last;
    logic             accept, refuse;
    logic             done_q, err_q;

    sram_lane_decode #(.LANES(LANES)) u_decode (
        .size      (acc_size_e'(req_size)),
        .offset    (req_offset),
        .lane_mask (dec_mask),
        .reject    (dec_reject)
    );

    sram_strobe_timer #(.CYCLES(STROBE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_STROBE),
        .last  (strobe_last)
    );

    sram_rd_capture #(.LANES(LANES)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (strobe_last && !wr_q),
        .lane_mask (mask_q),
        .bus_data  (mem_rdata),
        .rdata     (rsp_rdata)
    );

    assign accept = (state == ST_IDLE) && req_valid && !dec_reject;
    assign refuse = (state == ST_IDLE) && req_valid &&  dec_reject;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (accept) state_nx = ST_SETUP;
            ST_SETUP:   state_nx = ST_STROBE;
            ST_STROBE:  if (strobe_last) state_nx = ST_RECOVER;
            ST_RECOVER: state_nx = ST_IDLE;
        endcase
    end

    // request capture and response pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= dec_mask;
                wr_q    <= req_write;
            end
            done_q <= strobe_last;
            err_q  <= refuse;
        end
    end

    // outputs
    always_comb begin
        mem_cs_n     = '1;
        mem_we_n     = 1'b1;
        mem_oe_n     = 1'b1;
        mem_wdata_oe = 1'b0;
        unique case (state)
            ST_IDLE, ST_SETUP: ;
            ST_STROBE: begin
                mem_cs_n     = ~mask_q;
                mem_we_n     = !wr_q;
                mem_oe_n     = wr_q;
                mem_wdata_oe = wr_q;
            end
            ST_RECOVER: mem_wdata_oe = wr_q;
        endcase
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign busy      = (state != ST_IDLE);
    assign rsp_done  = done_q;
    assign rsp_error = err_q;

    AST_SEL_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs_n != '1) |-> ($countones(~mem_cs_n) == 1 || $countones(~mem_cs_n) == 2
                              || $countones(~mem_cs_n) == LANES)); // R1
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs_n != '1) |-> $stable(mem_addr)); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n)); // R7
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> $stable(mem_wdata)); // R6
    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_wdata_oe); // R6
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wdata_oe |-> mem_oe_n); // R10
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_wdata_oe)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R8
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> (mem_cs_n == '1 && !busy && !rsp_done)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_cs_n == '1 && mem_we_n && mem_oe_n && !mem_wdata_oe)); // R11
endmodule

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb;
    localparam int EXP_STROBE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [1:0]  req_size = '0, req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, rsp_done, rsp_error;
    logic [31:0] rsp_rdata, mem_wdata, mem_rdata;
    logic [16:0] mem_addr;
    logic [3:0]  mem_cs_n;
    logic        mem_we_n, mem_oe_n, mem_wdata_oe;

    always #2.5 clk = ~clk;

    sram_lane_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_offset(req_offset),
        .req_wdata(req_wdata), .busy(busy), .rsp_done(rsp_done),
        .rsp_error(rsp_error), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] init_byte(input int k, input int i);
        return 8'(i * 16 + k * 4 + 1);
    endfunction

    // bank model: junk on unselected lanes
    logic [7:0]  bank [0:3][0:15];
    logic [31:0] shadow [0:15];

    initial begin
        for (int i = 0; i < 16; i++)
            for (int k = 0; k < 4; k++) begin
                bank[k][i] = init_byte(k, i);
                shadow[i][8*k +: 8] = init_byte(k, i);
            end
    end

    always @(posedge clk)
        for (int k = 0; k < 4; k++)
            if (!mem_cs_n[k] && !mem_we_n && mem_wdata_oe)
                bank[k][mem_addr[3:0]] <= mem_wdata[8*k +: 8];

    always_comb
        for (int k = 0; k < 4; k++)
            mem_rdata[8*k +: 8] = (!mem_cs_n[k] && !mem_oe_n) ? bank[k][mem_addr[3:0]] : 8'hA5;

    // scoreboard
    typedef struct { bit err; bit rd; logic [31:0] data; } exp_t;
    exp_t sbq[$];

    always @(negedge clk) begin
        if (rst_n && (rsp_done || rsp_error)) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R4", {30'b0, rsp_error, rsp_done}, 32'h0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(rsp_error == e.err, "R4", 32'(rsp_error), 32'(e.err));
                check(rsp_done == !e.err, "R8", 32'(rsp_done), 32'(!e.err));
                if (e.rd && !e.err) check(rsp_rdata == e.data, "R8", rsp_rdata, e.data);
            end
        end
    end

    // turnaround monitor
    logic prev_drv = 1'b0, prev_oe_n = 1'b1;
    always @(negedge clk) begin
        if (rst_n && !mem_oe_n && prev_oe_n)
            check(!prev_drv, "R10", 32'(prev_drv), 32'h0);
        if (rst_n && !mem_oe_n)
            check(!mem_wdata_oe, "R10", 32'(mem_wdata_oe), 32'h0);
        prev_drv  = mem_wdata_oe;
        prev_oe_n = mem_oe_n;
    end

    task automatic do_req(input bit wr, input logic [16:0] a, input logic [1:0] sz,
                          input logic [1:0] off, input logic [31:0] wd, input bit intrude);
        logic [3:0]  m;
        bit          err;
        exp_t        e;
        string       tag;
        m = 4'h0; err = 1'b0;
        case (sz)
            2'b00: m = 4'b0001 << off;
            2'b01: if (off[0]) err = 1'b1; else m = 4'b0011 << off;
            2'b10: if (off != 2'd0) err = 1'b1; else m = 4'hF;
            default: err = 1'b1;
        endcase
        tag = (sz == 2'b00) ? "R1" : (sz == 2'b01) ? "R2" : "R3";
        e.err = err; e.rd = !wr; e.data = '0;
        for (int k = 0; k < 4; k++)
            if (m[k]) e.data[8*k +: 8] = shadow[a[3:0]][8*k +: 8];
        if (wr && !err)
            for (int k = 0; k < 4; k++)
                if (m[k]) shadow[a[3:0]][8*k +: 8] = wd[8*k +: 8];
        sbq.push_back(e);

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        req_size = sz; req_offset = off; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (err) begin
            check(mem_cs_n == 4'hF, "R4", 32'(mem_cs_n), 32'hF);
            check(!busy, "R4", 32'(busy), 32'h0);
            @(negedge clk);
            check(!busy && mem_cs_n == 4'hF, "R4", 32'(busy), 32'h0);
            return;
        end
        // SETUP
        check(busy, "R5", 32'(busy), 32'h1);
        check(mem_cs_n == 4'hF, "R9", 32'(mem_cs_n), 32'hF);
        check(mem_addr == a, "R9", 32'(mem_addr), 32'(a));
        if (intrude) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = a + 17'd1;
            req_size = 2'b10; req_offset = 2'd0; req_wdata = ~wd;
        end
        for (int i = 0; i < EXP_STROBE; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            check(mem_cs_n == ~m, tag, 32'(mem_cs_n), 32'(~m));
            check(mem_we_n == !wr, wr ? "R6" : "R7", 32'(mem_we_n), 32'(!wr));
            check(mem_oe_n == wr, wr ? "R6" : "R7", 32'(mem_oe_n), 32'(wr));
            check(mem_wdata_oe == wr, wr ? "R6" : "R7", 32'(mem_wdata_oe), 32'(wr));
            if (wr) check(mem_wdata == wd, "R6", mem_wdata, wd);
            check(mem_addr == a, "R9", 32'(mem_addr), 32'(a));
        end
        // RECOVER
        @(negedge clk);
        check(mem_cs_n == 4'hF && mem_we_n && mem_oe_n, "R5", 32'(mem_cs_n), 32'hF);
        check(mem_wdata_oe == wr, "R6", 32'(mem_wdata_oe), 32'(wr));
        check(busy && rsp_done, "R8", {30'b0, busy, rsp_done}, 32'h3);
        // IDLE
        @(negedge clk);
        check(!busy && !mem_wdata_oe && !rsp_done, "R5", {30'b0, busy, mem_wdata_oe}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(mem_cs_n == 4'hF && mem_we_n && mem_oe_n, "R11", 32'(mem_cs_n), 32'hF);
        check(!mem_wdata_oe && !busy && !rsp_done && !rsp_error, "R11", 32'(busy), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && mem_cs_n == 4'hF, "R11", 32'(busy), 32'h0);

        do_req(1'b1, 17'h00001, 2'b10, 2'd0, 32'h11223344, 1'b0);   // R3 write
        do_req(1'b0, 17'h00001, 2'b10, 2'd0, 32'h0, 1'b0);          // R3 read after write, R10
        do_req(1'b1, 17'h10002, 2'b00, 2'd2, 32'hDEADBEEF, 1'b0);   // R1 single lane
        do_req(1'b0, 17'h10002, 2'b00, 2'd2, 32'h0, 1'b0);          // R8 zero fill
        do_req(1'b0, 17'h10002, 2'b10, 2'd0, 32'h0, 1'b0);          // R1 neighbours untouched
        do_req(1'b1, 17'h00003, 2'b01, 2'd2, 32'hCAFEF00D, 1'b0);   // R2 upper pair
        do_req(1'b0, 17'h00003, 2'b01, 2'd0, 32'h0, 1'b0);          // R2 lower pair
        do_req(1'b0, 17'h00003, 2'b10, 2'd0, 32'h0, 1'b0);
        for (int k = 0; k < 4; k++)
            do_req(1'b0, 17'h00005, 2'b00, 2'(k), 32'h0, 1'b0);     // R1 each lane
        do_req(1'b1, 17'h00001, 2'b01, 2'd1, 32'hFFFFFFFF, 1'b0);   // R4 odd half
        do_req(1'b1, 17'h00001, 2'b10, 2'd2, 32'hFFFFFFFF, 1'b0);   // R4 offset word
        do_req(1'b1, 17'h00001, 2'b11, 2'd0, 32'hFFFFFFFF, 1'b0);   // R4 reserved size
        do_req(1'b0, 17'h00001, 2'b10, 2'd0, 32'h0, 1'b0);          // R4 memory unchanged
        do_req(1'b1, 17'h00006, 2'b10, 2'd0, 32'h0BADF00D, 1'b1);   // R5 intrusion ignored
        do_req(1'b0, 17'h00007, 2'b10, 2'd0, 32'h0, 1'b0);
        do_req(1'b0, 17'h00006, 2'b10, 2'd0, 32'h0, 1'b0);
        for (int i = 8; i < 12; i++) begin                           // R10 write then read
            do_req(1'b1, 17'(i), 2'b01, 2'd0, 32'(i * 32'h01010101), 1'b0);
            do_req(1'b0, 17'(i), 2'b10, 2'd0, 32'h0, 1'b0);
        end

        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "R8", 32'(sbq.size()), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R5 actual=%h expected=%h", 32'h1, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule